// File: doc/BRIEF.md
# Protected Memory Window Router

This block sits in the request path of a memory controller and decides, for every 32-bit physical request, whether it goes to DRAM, to the legacy video target, or is refused. The decision uses three inputs: the address, a flag that says whether the requester is running in system management mode, and a small bank of configuration registers. Two address windows are guarded. The first is a fixed 128 KB legacy window. The second is a relocatable window near the top of memory whose base and power-of-two size are programmable.

Firmware sets up the windows through a simple register port. It may set an "open" control so that it can load handler code into protected DRAM without being privileged. It then sets a one-way lock. After the lock is set, the configuration cannot change until reset. A refused read completes with all-ones data. A refused write is dropped. Either kind of refusal raises a one-cycle violation pulse. The routing result is registered, so it appears one clock after the request strobe.

Top module: `smram_guard`

## Requirements
- R1: After synchronous reset, all three configuration registers read as zero, the lock is clear, and `rsp_valid` and `rsp_violation` are low.
- R2: When `req_valid` is high on a clock edge, `rsp_valid` is high for exactly the following cycle, and `rsp_addr` and `rsp_write` carry the request's address and direction. With no request, `rsp_valid` is low.
- R3: The legacy window spans 0x000A0000 to 0x000BFFFF. While its enable (control bit 0) is set, an unprivileged hit goes to VIDEO (target code 1) and a privileged hit goes to DRAM (target code 0). While the enable is clear, every hit goes to VIDEO.
- R4: While the top-window enable (control bit 1) is set, an unprivileged hit in [base, base+size) is refused (target code 2) and a privileged hit goes to DRAM.
- R5: A refused request raises `rsp_violation` for that response cycle only. A refused read returns `rsp_err_rdata` = 0xFFFFFFFF. A refused write returns 0 there, and in every other case `rsp_err_rdata` is 0.
- R6: A request that misses both guarded windows, or that hits a window whose enable is clear (the top window only), goes to DRAM whatever the mode flag.
- R7: While unlocked, the open bit (control bit 2) sends unprivileged hits in either enabled window to DRAM. Once the lock is set, the open bit reads 0 and has no effect.
- R8: Register 2 bits [1:0] hold a size code n, and the top window is then 1 MB << n. Register 1 holds the 32-bit base. A base write that is not a multiple of the current size is ignored. A size write under which the current base would be misaligned is ignored.
- R9: The lock (control bit 3) is set by writing 1 to it. Writing 0 does not clear it, and only reset does. When the lock is set, the open bit is forced to 0 in the same write. While locked, writes to every register are ignored.
- R10: When the two windows overlap, the legacy window's rule decides.
- R11: Register reads are combinational on `cfg_addr`: 0 returns the control bits in [3:0], 1 returns the base, 2 returns the size code in [1:0], and 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| req_valid | input | 1 | Memory request strobe |
| req_addr | input | 32 | Physical request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Requester is in system management mode |
| rsp_valid | output | 1 | Routing result valid |
| rsp_target | output | 2 | 0 DRAM, 1 VIDEO, 2 refused |
| rsp_addr | output | 32 | Address of the routed request |
| rsp_write | output | 1 | Direction of the routed request |
| rsp_violation | output | 1 | One-cycle access-violation pulse |
| rsp_err_rdata | output | 32 | All-ones completion data for a refused read |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 1 MB minimum top-window size and a two-bit size code. With these values every size from 1 MB to 8 MB can be reached. So can a top window that ends exactly at the 4 GB boundary, where a base-plus-size sum overflows 32 bits. A 1 MB window at base zero can be placed over the legacy window to exercise the overlap rule. A behavioural model in the bench uses 64-bit range comparisons. It is compared with the design on every clock, so both the window edges and the ignored configuration writes are checked all the way through the lock.

// File: rtl/smram_pkg.sv
package smram_pkg;

    typedef enum logic [1:0] {
        TGT_DRAM   = 2'd0,
        TGT_VIDEO  = 2'd1,
        TGT_REJECT = 2'd2
    } tgt_e;

    // Control register layout, MSB first: bit3 lock, bit2 open, bit1 top enable, bit0 legacy enable
    typedef struct packed {
        logic lock;
        logic open;
        logic top_en;
        logic leg_en;
    } ctrl_t;

    typedef struct packed {
        logic leg_hit;
        logic top_hit;
    } hit_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_BASE = 2'd1;
    localparam logic [1:0] REG_SIZE = 2'd2;

    localparam logic [31:0] LEG_BASE  = 32'h000A_0000;
    localparam int          LEG_LOG2  = 17;

    // Routing rule; the legacy window decides first when both windows match
    function automatic tgt_e pick_target(input hit_t h, input ctrl_t c, input logic smm);
        logic priv;
        priv = smm || (c.open && !c.lock);
        if (h.leg_hit) begin
            if (!c.leg_en)  return TGT_VIDEO;
            return priv ? TGT_DRAM : TGT_VIDEO;
        end
        if (h.top_hit && c.top_en) begin
            return priv ? TGT_DRAM : TGT_REJECT;
        end
        return TGT_DRAM;
    endfunction

endpackage

// File: rtl/smram_cfg.sv
module smram_cfg
    import smram_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 20,
    parameter int SIZE_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] top_base,
    output logic [SIZE_W-1:0] top_size
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] base_q;
    logic [SIZE_W-1:0] size_q;

    logic [ADDR_W-1:0] cur_mask;
    logic [ADDR_W-1:0] new_mask;
    logic [SIZE_W-1:0] new_size;
    logic              base_ok;
    logic              size_ok;

    always_comb begin
        new_size = cfg_wdata[SIZE_W-1:0];
        cur_mask = (ONE << (MIN_SHIFT + int'(size_q))) - ONE;
        new_mask = (ONE << (MIN_SHIFT + int'(new_size))) - ONE;
        base_ok  = (cfg_wdata & cur_mask) == '0;
        size_ok  = (base_q & new_mask) == '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            base_q <= '0;
            size_q <= '0;
        end else if (cfg_we && !ctrl_q.lock) begin
            case (cfg_addr)
                REG_CTRL: begin
                    ctrl_q.leg_en <= cfg_wdata[0];
                    ctrl_q.top_en <= cfg_wdata[1];
                    ctrl_q.open   <= cfg_wdata[2] && !cfg_wdata[3];
                    ctrl_q.lock   <= cfg_wdata[3];
                end
                REG_BASE: if (base_ok) base_q <= cfg_wdata;
                REG_SIZE: if (size_ok) size_q <= new_size;
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_CTRL: cfg_rdata[3:0]        = ctrl_q;
            REG_BASE: cfg_rdata             = base_q;
            REG_SIZE: cfg_rdata[SIZE_W-1:0] = size_q;
            default:  cfg_rdata             = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign top_base = base_q;
    assign top_size = size_q;

    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.lock |=> ctrl_q.lock);

    p_locked_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.lock |=> ($stable(base_q) && $stable(size_q) && $stable(ctrl_q)));

    p_open_dropped_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.lock |-> !ctrl_q.open);

    p_base_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        (base_q & cur_mask) == '0);

endmodule

// File: rtl/smram_decode.sv
module smram_decode
    import smram_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 20,
    parameter int SIZE_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] top_base,
    input  logic [SIZE_W-1:0] top_size,
    output hit_t              hit
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] LEG = LEG_BASE[ADDR_W-1:0];

    logic [ADDR_W-1:0] span;

    always_comb begin
        span        = (ONE << (MIN_SHIFT + int'(top_size))) - ONE;
        hit.leg_hit = addr[ADDR_W-1:LEG_LOG2] == LEG[ADDR_W-1:LEG_LOG2];
        hit.top_hit = ((addr ^ top_base) & ~span) == '0;
    end

endmodule

// File: rtl/smram_route.sv
module smram_route
    import smram_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_smm,
    input  hit_t              hit,
    input  ctrl_t             ctrl,
    output logic              rsp_valid,
    output tgt_e              rsp_target,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_write,
    output logic              rsp_violation,
    output logic [ADDR_W-1:0] rsp_err_rdata
);

    tgt_e next_tgt;

    always_comb next_tgt = pick_target(hit, ctrl, req_smm);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_target    <= TGT_DRAM;
            rsp_addr      <= '0;
            rsp_write     <= 1'b0;
            rsp_violation <= 1'b0;
            rsp_err_rdata <= '0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_violation <= req_valid && (next_tgt == TGT_REJECT);
            rsp_err_rdata <= (req_valid && next_tgt == TGT_REJECT && !req_write) ? '1 : '0;
            if (req_valid) begin
                rsp_target <= next_tgt;
                rsp_addr   <= req_addr;
                rsp_write  <= req_write;
            end
        end
    end

    p_resp_next_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_resp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_smm_served_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_smm) |=> (rsp_target != TGT_REJECT && !rsp_violation));

    p_viol_target_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_violation |-> (rsp_valid && rsp_target == TGT_REJECT));

    p_err_ones_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_violation && !rsp_write) |-> (rsp_err_rdata == '1));

    p_outside_dram_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !hit.leg_hit && !hit.top_hit) |=> (rsp_target == TGT_DRAM));

endmodule

// File: rtl/smram_guard.sv
module smram_guard
    import smram_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MIN_SHIFT = 20,
    parameter int SIZE_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_smm,
    output logic              rsp_valid,
    output logic [1:0]        rsp_target,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_write,
    output logic              rsp_violation,
    output logic [ADDR_W-1:0] rsp_err_rdata
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] top_base;
    logic [SIZE_W-1:0] top_size;
    hit_t              hit;
    tgt_e              tgt;

    smram_cfg #(.ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT), .SIZE_W(SIZE_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .ctrl     (ctrl),
        .top_base (top_base),
        .top_size (top_size)
    );

    smram_decode #(.ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT), .SIZE_W(SIZE_W)) u_dec (
        .addr    (req_addr),
        .top_base(top_base),
        .top_size(top_size),
        .hit     (hit)
    );

    smram_route #(.ADDR_W(ADDR_W)) u_route (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_smm      (req_smm),
        .hit          (hit),
        .ctrl         (ctrl),
        .rsp_valid    (rsp_valid),
        .rsp_target   (tgt),
        .rsp_addr     (rsp_addr),
        .rsp_write    (rsp_write),
        .rsp_violation(rsp_violation),
        .rsp_err_rdata(rsp_err_rdata)
    );

    assign rsp_target = tgt;

    p_overlap_legacy_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hit.leg_hit) |=> (rsp_target != 2'd2));

endmodule

// File: tb/tb_smram_guard.sv
module tb_smram_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_smm = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_target;
    logic [31:0] rsp_addr;
    logic        rsp_write;
    logic        rsp_violation;
    logic [31:0] rsp_err_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    smram_guard dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_smm(req_smm),
        .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_addr(rsp_addr),
        .rsp_write(rsp_write), .rsp_violation(rsp_violation), .rsp_err_rdata(rsp_err_rdata)
    );

    // Behavioural reference state
    logic [3:0]  m_ctrl;
    logic [31:0] m_base;
    int          m_size;
    logic        e_valid, e_write, e_viol;
    logic [1:0]  e_tgt;
    logic [31:0] e_addr, e_err;

    function automatic logic [1:0] model_route(input logic [31:0] a, input logic smm);
        longint unsigned lo, span, aa;
        bit in_leg, in_top, priv;
        aa     = longint'(a);
        lo     = longint'(m_base);
        span   = 64'd1 << (20 + m_size);
        in_leg = (a >= 32'h000A0000) && (a <= 32'h000BFFFF);
        in_top = (aa >= lo) && (aa < lo + span);
        priv   = smm || m_ctrl[2];
        if (in_leg) return (m_ctrl[0] && priv) ? 2'd0 : 2'd1;
        if (in_top && m_ctrl[1]) return priv ? 2'd0 : 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return {28'd0, m_ctrl};
            2'd1: return m_base;
            2'd2: return 32'(m_size);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 4'd0; m_base = 32'd0; m_size = 0;
            e_valid = 1'b0; e_viol = 1'b0; e_err = 32'd0;
        end else begin
            e_valid = req_valid;
            e_viol  = 1'b0;
            e_err   = 32'd0;
            if (req_valid) begin
                e_tgt   = model_route(req_addr, req_smm);
                e_addr  = req_addr;
                e_write = req_write;
                e_viol  = (e_tgt == 2'd2);
                e_err   = (e_viol && !req_write) ? 32'hFFFFFFFF : 32'd0;
            end
            if (cfg_we && !m_ctrl[3]) begin
                if (cfg_addr == 2'd0) begin
                    m_ctrl = {cfg_wdata[3], cfg_wdata[2] & ~cfg_wdata[3], cfg_wdata[1], cfg_wdata[0]};
                end else if (cfg_addr == 2'd1) begin
                    if ((longint'(cfg_wdata) % (64'd1 << (20 + m_size))) == 0) m_base = cfg_wdata;
                end else if (cfg_addr == 2'd2) begin
                    if ((longint'(m_base) % (64'd1 << (20 + int'(cfg_wdata[1:0])))) == 0)
                        m_size = int'(cfg_wdata[1:0]);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            chk(rsp_valid == e_valid, cur_tag, "model rsp_valid", 32'(rsp_valid), 32'(e_valid));
            chk(rsp_violation == e_viol, cur_tag, "model violation", 32'(rsp_violation), 32'(e_viol));
            chk(rsp_err_rdata == e_err, cur_tag, "model err_rdata", rsp_err_rdata, e_err);
            chk(cfg_rdata == model_read(cfg_addr), cur_tag, "model cfg_rdata", cfg_rdata, model_read(cfg_addr));
            if (e_valid) begin
                chk(rsp_target == e_tgt, cur_tag, "model target", 32'(rsp_target), 32'(e_tgt));
                chk(rsp_addr == e_addr, cur_tag, "model addr", rsp_addr, e_addr);
                chk(rsp_write == e_write, cur_tag, "model write", 32'(rsp_write), 32'(e_write));
            end
        end
    end

    task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == exp, tag, "register read", cfg_rdata, exp);
    endtask

    task automatic do_req(input logic [31:0] a, input bit wr, input bit smm,
                          input logic [1:0] exp_tgt, input string tag);
        logic [31:0] exp_err;
        cur_tag = tag;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_smm = smm;
        @(posedge clk);
        #2;
        exp_err = (exp_tgt == 2'd2 && !wr) ? 32'hFFFFFFFF : 32'd0;
        chk(rsp_valid == 1'b1, tag, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_target == exp_tgt, tag, "target", 32'(rsp_target), 32'(exp_tgt));
        chk(rsp_violation == (exp_tgt == 2'd2), tag, "violation", 32'(rsp_violation), 32'(exp_tgt == 2'd2));
        chk(rsp_err_rdata == exp_err, tag, "err_rdata", rsp_err_rdata, exp_err);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cfg_rd(2'd0, 32'd0, "R1");
        cfg_rd(2'd1, 32'd0, "R1");
        cfg_rd(2'd2, 32'd0, "R1");
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        cfg_rd(2'd3, 32'd0, "R11");

        // Legacy enable clear: all hits go to video
        do_req(32'h000A0000, 1'b0, 1'b1, 2'd1, "R3");
        do_req(32'h00100000, 1'b0, 1'b0, 2'd0, "R6");

        // R2 one-cycle latency and idle cycle
        cur_tag = "R2";
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "idle rsp_valid", 32'(rsp_valid), 32'd0);

        // R8 size and base rules
        cfg_wr(2'd2, 32'd3);
        cfg_rd(2'd2, 32'd3, "R8");
        cfg_wr(2'd1, 32'h00100000);
        cfg_rd(2'd1, 32'd0, "R8");
        cfg_wr(2'd2, 32'd0);
        cfg_wr(2'd1, 32'h7FF00000);
        cfg_rd(2'd1, 32'h7FF00000, "R8");
        cfg_wr(2'd2, 32'd3);
        cfg_rd(2'd2, 32'd0, "R8");
        cfg_wr(2'd1, 32'hFF800000);
        cfg_wr(2'd2, 32'd3);
        cfg_rd(2'd2, 32'd3, "R8");

        // Enable both windows
        cfg_wr(2'd0, 32'h3);
        cfg_rd(2'd0, 32'h3, "R11");
        do_req(32'h000A0000, 1'b0, 1'b0, 2'd1, "R3");
        do_req(32'h000BFFFF, 1'b1, 1'b0, 2'd1, "R3");
        do_req(32'h000A0000, 1'b0, 1'b1, 2'd0, "R3");
        do_req(32'h0009FFFF, 1'b0, 1'b0, 2'd0, "R6");
        do_req(32'h000C0000, 1'b0, 1'b0, 2'd0, "R6");
        do_req(32'hFF800000, 1'b0, 1'b0, 2'd2, "R4");
        do_req(32'hFFFFFFFC, 1'b1, 1'b0, 2'd2, "R5");
        chk(rsp_write == 1'b1, "R2", "rsp_write", 32'(rsp_write), 32'd1);
        cur_tag = "R5";
        @(negedge clk);
        chk(rsp_violation == 1'b0, "R5", "violation after pulse", 32'(rsp_violation), 32'd0);
        do_req(32'hFF7FFFFF, 1'b0, 1'b0, 2'd0, "R6");
        do_req(32'hFFFFFFFF, 1'b0, 1'b1, 2'd0, "R4");
        chk(rsp_addr == 32'hFFFFFFFF, "R2", "rsp_addr", rsp_addr, 32'hFFFFFFFF);

        // R7 open bit while unlocked
        cfg_wr(2'd0, 32'h7);
        do_req(32'h000A0000, 1'b0, 1'b0, 2'd0, "R7");
        do_req(32'hFF900000, 1'b0, 1'b0, 2'd0, "R7");

        // R10 overlap: 1 MB window at zero covers the legacy window
        cfg_wr(2'd0, 32'h3);
        cfg_wr(2'd2, 32'd0);
        cfg_wr(2'd1, 32'h0);
        do_req(32'h000A0000, 1'b0, 1'b0, 2'd1, "R10");
        do_req(32'h00050000, 1'b0, 1'b0, 2'd2, "R10");
        cfg_wr(2'd1, 32'hFF800000);
        cfg_wr(2'd2, 32'd3);

        // R9 lock
        cfg_wr(2'd0, 32'hF);
        cfg_rd(2'd0, 32'hB, "R9");
        do_req(32'h000A0000, 1'b0, 1'b0, 2'd1, "R7");
        cur_tag = "R9";
        cfg_wr(2'd0, 32'h0);
        cfg_rd(2'd0, 32'hB, "R9");
        cfg_wr(2'd1, 32'h0);
        cfg_rd(2'd1, 32'hFF800000, "R9");
        cfg_wr(2'd2, 32'd0);
        cfg_rd(2'd2, 32'd3, "R9");
        do_req(32'hFF800010, 1'b0, 1'b0, 2'd2, "R9");

        // Reset clears the lock
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cfg_rd(2'd0, 32'd0, "R9");
        cfg_wr(2'd0, 32'h1);
        cfg_rd(2'd0, 32'h1, "R9");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule